// File: doc/BRIEF.md
# Programmable TFT Display Timing Generator

This block produces the strobes that drive an active-matrix panel: a pixel clock, horizontal sync, vertical sync and data-enable. It also reports the current active column and row, and gives a one-cycle pulse when a frame begins. The geometry is set through a small write-only register set: sync widths, back porches, front porches, active column count and active line count. A divider derives the pixel rate from the bus clock. Each outgoing strobe has its own polarity-invert bit.

Software writes the geometry, the divider and the polarity while the generator is stopped, then sets the enable bit with the panel mode field at the TFT value. Geometry, divider and polarity written while the generator runs are staged. They are applied only at the next frame boundary, so a frame never changes shape partway through. Fetching pixel data and supporting passive panels are left to other blocks.

Top module: `tft_tg`

## Requirements
- R1: After reset, and while the generator is stopped, every strobe rests at its inactive level. The inactive level equals that strobe's invert bit. The column and row outputs read 0 and no frame pulse occurs. The generator stops one clock after the enable is cleared.
- R2: One pixel lasts 2*(DIV+1) bus clocks. DIV is bits 17:8 of register 0. Within each pixel, the uninverted pixel clock is low for the first DIV+1 bus clocks and high for the remaining DIV+1.
- R3: Each line consists of HSW pixels with hsync asserted, then HBP back-porch pixels, HACT active pixels and HFP front-porch pixels, in that order. Register 2 holds HBP-1 in bits 25:19, HACT-1 in bits 18:8 and HFP-1 in bits 7:0. Register 3 holds HSW-1 in bits 7:0.
- R4: Each frame consists of VSW lines with vsync asserted, then VBP, VACT and VFP lines, in that order. Register 1 holds VBP-1 in bits 31:24, VACT-1 in bits 23:14, VFP-1 in bits 13:6 and VSW-1 in bits 5:0. The vertical position moves only at the end of a line.
- R5: Data-enable is asserted only while both the horizontal and vertical positions lie in their active regions. The column output gives the pixel index within the active region of the line and reads 0 outside it. The row output gives the line index within the active lines and reads 0 outside them.
- R6: Register 4 holds the invert bits: pixel clock in bit 10, hsync in bit 9, vsync in bit 8, data in bit 7 and data-enable in bit 6. A set bit inverts that output. The data bit appears directly on `data_inv_o`.
- R7: `frame_start_o` pulses for one bus clock in the last bus clock of the first pixel of every frame (line 0, column 0). `frame_irq_o` repeats that pulse unless the mask bit, bit 0 of register 5, is set.
- R8: The generator starts when register 0 bit 0 is set. The first bus clock of pixel 0 comes two clocks after the write edge. Geometry written while the generator runs has no effect until the next frame boundary, where it takes effect.
- R9: The generator runs only when the panel mode field (register 0, bits 6:5) equals 3. With any other value it stays stopped, as described in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index (0 to 5) |
| wr_data | input | 32 | Register write data |
| pclk_o | output | 1 | Pixel clock after polarity |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data-enable after polarity |
| data_inv_o | output | 1 | Pixel data invert flag |
| col_o | output | 11 | Active column index |
| row_o | output | 10 | Active row index |
| frame_start_o | output | 1 | One-clock frame start pulse |
| frame_irq_o | output | 1 | Frame pulse gated by the mask bit |

## Verification
The bench builds the block with the default field widths, because the geometry is set at run time rather than by parameters. It programs a tiny 8-by-5 pixel frame, so a complete frame takes only 80 bus clocks at the fastest divider setting. This puts several frame wraps, a slower divider setting of 2, an inverted-polarity run and a mid-frame geometry rewrite, held back until the next frame, all within a short run. The bench predicts every output in every clock from pixel arithmetic on the elapsed clock count.

// File: rtl/tft_tg_pkg.sv
package tft_tg_pkg;

    localparam int DIV_W  = 10;
    localparam int HSW_W  = 8;
    localparam int HBP_W  = 7;
    localparam int HACT_W = 11;
    localparam int HFP_W  = 8;
    localparam int VSW_W  = 6;
    localparam int VBP_W  = 8;
    localparam int VACT_W = 10;
    localparam int VFP_W  = 8;
    localparam int REG_AW = 3;
    localparam int REG_DW = 32;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    localparam int H_CW = max4(HSW_W, HBP_W, HACT_W, HFP_W);
    localparam int V_CW = max4(VSW_W, VBP_W, VACT_W, VFP_W);

    localparam logic [1:0] MODE_TFT = 2'd3;

    typedef enum logic [REG_AW-1:0] {
        RG_CTRL  = 3'd0,
        RG_VERT  = 3'd1,
        RG_HORZ  = 3'd2,
        RG_HSYNC = 3'd3,
        RG_POL   = 3'd4,
        RG_MASK  = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        SEG_SYNC   = 2'd0,
        SEG_BACK   = 2'd1,
        SEG_ACTIVE = 2'd2,
        SEG_FRONT  = 2'd3
    } seg_e;

    typedef struct packed {
        logic inv_clk;
        logic inv_hs;
        logic inv_vs;
        logic inv_data;
        logic inv_de;
    } pol_t;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [HSW_W-1:0]  hsw;
        logic [HBP_W-1:0]  hbp;
        logic [HACT_W-1:0] hact;
        logic [HFP_W-1:0]  hfp;
        logic [VSW_W-1:0]  vsw;
        logic [VBP_W-1:0]  vbp;
        logic [VACT_W-1:0] vact;
        logic [VFP_W-1:0]  vfp;
        pol_t              pol;
    } geom_t;

endpackage

// File: rtl/tft_tg_regs.sv
module tft_tg_regs
    import tft_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic              frame_wrap,
    output logic              run,
    output logic              irq_mask,
    output geom_t             cur
);

    geom_t      stage;
    logic       en_q;
    logic [1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage    <= '0;
            en_q     <= 1'b0;
            mode_q   <= 2'd0;
            irq_mask <= 1'b0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                RG_CTRL: begin
                    en_q      <= wr_data[0];
                    mode_q    <= wr_data[6:5];
                    stage.div <= wr_data[17:8];
                end
                RG_VERT: begin
                    stage.vbp  <= wr_data[31:24];
                    stage.vact <= wr_data[23:14];
                    stage.vfp  <= wr_data[13:6];
                    stage.vsw  <= wr_data[5:0];
                end
                RG_HORZ: begin
                    stage.hbp  <= wr_data[25:19];
                    stage.hact <= wr_data[18:8];
                    stage.hfp  <= wr_data[7:0];
                end
                RG_HSYNC: stage.hsw <= wr_data[7:0];
                RG_POL: begin
                    stage.pol.inv_clk  <= wr_data[10];
                    stage.pol.inv_hs   <= wr_data[9];
                    stage.pol.inv_vs   <= wr_data[8];
                    stage.pol.inv_data <= wr_data[7];
                    stage.pol.inv_de   <= wr_data[6];
                end
                RG_MASK: irq_mask <= wr_data[0];
                default: ;
            endcase
        end
    end

    // Run flag lags the enable by one clock; the working copy follows the
    // staged copy while stopped and is refreshed only at a frame wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cur <= '0;
        end else begin
            run <= en_q && (mode_q == MODE_TFT);
            if (!run || frame_wrap)
                cur <= stage;
        end
    end

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !frame_wrap) |=> $stable(cur));

endmodule

// File: rtl/tft_tg_clkdiv.sv
module tft_tg_clkdiv #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          phase,
    output logic          pix_en
);

    logic [DW-1:0] cnt;
    logic          at_top;

    assign at_top = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (at_top) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign pix_en = run && phase && at_top;

    // R2
    pix_gap_chk: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> !pix_en);

endmodule

// File: rtl/tft_tg_axis.sv
module tft_tg_axis
    import tft_tg_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                adv,
    input  logic [3:0][CW-1:0]  seg_len,
    output seg_e                seg,
    output logic [CW-1:0]       cnt,
    output logic                last
);

    logic seg_end;

    assign seg_end = (cnt == seg_len[seg]);
    assign last    = adv && seg_end && (seg == SEG_FRONT);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            seg <= SEG_SYNC;
            cnt <= '0;
        end else if (adv) begin
            if (seg_end) begin
                cnt <= '0;
                seg <= seg_e'(2'(seg + 2'd1));
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3
    seg_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |-> (cnt <= seg_len[seg]));

endmodule

// File: rtl/tft_tg.sv
module tft_tg
    import tft_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    output logic              pclk_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              data_inv_o,
    output logic [H_CW-1:0]   col_o,
    output logic [V_CW-1:0]   row_o,
    output logic              frame_start_o,
    output logic              frame_irq_o
);

    logic                 run;
    logic                 irq_mask;
    geom_t                cur;
    logic                 phase;
    logic                 pix_en;
    logic [3:0][H_CW-1:0] h_len;
    logic [3:0][V_CW-1:0] v_len;
    seg_e                 h_seg;
    seg_e                 v_seg;
    logic [H_CW-1:0]      h_cnt;
    logic [V_CW-1:0]      v_cnt;
    logic                 h_last;
    logic                 v_last;
    logic                 h_act;
    logic                 v_act;
    logic                 hs_raw;
    logic                 vs_raw;
    logic                 de_raw;
    logic                 origin;
    logic                 fs;

    tft_tg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_wrap (v_last),
        .run        (run),
        .irq_mask   (irq_mask),
        .cur        (cur)
    );

    tft_tg_clkdiv #(.DW(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .div    (cur.div),
        .phase  (phase),
        .pix_en (pix_en)
    );

    assign h_len = {H_CW'(cur.hfp), H_CW'(cur.hact), H_CW'(cur.hbp), H_CW'(cur.hsw)};
    assign v_len = {V_CW'(cur.vfp), V_CW'(cur.vact), V_CW'(cur.vbp), V_CW'(cur.vsw)};

    tft_tg_axis #(.CW(H_CW)) u_haxis (
        .clk     (clk),
        .rst     (rst),
        .clear   (!run),
        .adv     (pix_en),
        .seg_len (h_len),
        .seg     (h_seg),
        .cnt     (h_cnt),
        .last    (h_last)
    );

    tft_tg_axis #(.CW(V_CW)) u_vaxis (
        .clk     (clk),
        .rst     (rst),
        .clear   (!run),
        .adv     (h_last),
        .seg_len (v_len),
        .seg     (v_seg),
        .cnt     (v_cnt),
        .last    (v_last)
    );

    assign h_act  = run && (h_seg == SEG_ACTIVE);
    assign v_act  = run && (v_seg == SEG_ACTIVE);
    assign hs_raw = run && (h_seg == SEG_SYNC);
    assign vs_raw = run && (v_seg == SEG_SYNC);
    assign de_raw = h_act && v_act;
    assign origin = (h_seg == SEG_SYNC) && (h_cnt == '0) &&
                    (v_seg == SEG_SYNC) && (v_cnt == '0);
    assign fs     = pix_en && origin;

    assign pclk_o        = (run && phase) ^ cur.pol.inv_clk;
    assign hsync_o       = hs_raw ^ cur.pol.inv_hs;
    assign vsync_o       = vs_raw ^ cur.pol.inv_vs;
    assign de_o          = de_raw ^ cur.pol.inv_de;
    assign data_inv_o    = cur.pol.inv_data;
    assign col_o         = h_act ? h_cnt : '0;
    assign row_o         = v_act ? v_cnt : '0;
    assign frame_start_o = fs;
    assign frame_irq_o   = fs && !irq_mask;

    // R1
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (h_cnt == '0 && v_cnt == '0 && !pix_en));

    // R4
    vline_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !h_last) |=> ($stable(v_cnt) && $stable(v_seg)));

    // R5
    col_range_chk: assert property (@(posedge clk) disable iff (rst)
        de_raw |-> (col_o <= H_CW'(cur.hact)));

    // R7
    fs_single_chk: assert property (@(posedge clk) disable iff (rst)
        fs |=> !fs);

endmodule

// File: tb/tb_tft_tg.sv
module tb_tft_tg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pclk_o, hsync_o, vsync_o, de_o, data_inv_o;
    logic [10:0] col_o;
    logic [9:0]  row_o;
    logic        frame_start_o, frame_irq_o;

    always #2.5 clk = ~clk;

    tft_tg dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .data_inv_o(data_inv_o), .col_o(col_o), .row_o(row_o),
        .frame_start_o(frame_start_o), .frame_irq_o(frame_irq_o)
    );

    int vectors = 0;
    int errors  = 0;

    // geometry: hsw hbp hact hfp vsw vbp vact vfp div
    int ga[9];
    int gb[9];
    int k_switch = 1000000;
    bit p_clk, p_hs, p_vs, p_dat, p_de, mask;

    int e_pc, e_hs, e_vs, e_de, e_fs, e_col, e_row;

    task automatic cmp(input string req, input string name, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, name, act, exp, $time);
        end
    endtask

    function automatic void model(input int g[9], input int kk);
        int p, t, ph, ht, vt, hp, vl;
        bit hin, vin;
        p  = 2 * (g[8] + 1);
        t  = kk / p;
        ph = kk % p;
        ht = g[0] + g[1] + g[2] + g[3];
        vt = g[4] + g[5] + g[6] + g[7];
        hp = t % ht;
        vl = (t / ht) % vt;
        hin = (hp >= g[0] + g[1]) && (hp < g[0] + g[1] + g[2]);
        vin = (vl >= g[4] + g[5]) && (vl < g[4] + g[5] + g[6]);
        e_pc  = (ph >= g[8] + 1) ? 1 : 0;
        e_hs  = (hp < g[0]) ? 1 : 0;
        e_vs  = (vl < g[4]) ? 1 : 0;
        e_de  = (hin && vin) ? 1 : 0;
        e_col = hin ? hp - (g[0] + g[1]) : 0;
        e_row = vin ? vl - (g[4] + g[5]) : 0;
        e_fs  = ((ph == p - 1) && (t % (ht * vt) == 0)) ? 1 : 0;
    endfunction

    task automatic check_at(input int kk);
        if (kk < k_switch) model(ga, kk);
        else model(gb, kk - k_switch);
        cmp("R2", "pclk",  int'(pclk_o),  e_pc ^ int'(p_clk));
        cmp("R3", "hsync", int'(hsync_o), e_hs ^ int'(p_hs));
        cmp("R4", "vsync", int'(vsync_o), e_vs ^ int'(p_vs));
        cmp("R5", "de",    int'(de_o),    e_de ^ int'(p_de));
        cmp("R5", "col",   int'(col_o),   e_col);
        cmp("R5", "row",   int'(row_o),   e_row);
        cmp("R6", "data_inv", int'(data_inv_o), int'(p_dat));
        cmp("R7", "frame_start", int'(frame_start_o), e_fs);
        cmp("R7", "frame_irq", int'(frame_irq_o), mask ? 0 : e_fs);
    endtask

    task automatic idle_check(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp(req, "idle pclk",  int'(pclk_o),  int'(p_clk));
            cmp(req, "idle hsync", int'(hsync_o), int'(p_hs));
            cmp(req, "idle vsync", int'(vsync_o), int'(p_vs));
            cmp(req, "idle de",    int'(de_o),    int'(p_de));
            cmp(req, "idle col",   int'(col_o),   0);
            cmp(req, "idle row",   int'(row_o),   0);
            cmp(req, "idle frame_start", int'(frame_start_o), 0);
            cmp(req, "idle frame_irq",   int'(frame_irq_o),   0);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] enc_ctrl(input int en, input int mode, input int dv);
        return 32'((dv << 8) | (mode << 5) | en);
    endfunction

    function automatic logic [31:0] enc_vert(input int sw, input int bp, input int act, input int fp);
        return 32'(((bp - 1) << 24) | ((act - 1) << 14) | ((fp - 1) << 6) | (sw - 1));
    endfunction

    function automatic logic [31:0] enc_horz(input int bp, input int act, input int fp);
        return 32'(((bp - 1) << 19) | ((act - 1) << 8) | (fp - 1));
    endfunction

    function automatic logic [31:0] enc_pol();
        return 32'((int'(p_clk) << 10) | (int'(p_hs) << 9) | (int'(p_vs) << 8) |
                   (int'(p_dat) << 7) | (int'(p_de) << 6));
    endfunction

    task automatic stop_gen();
        wr(0, 32'd0);
        repeat (3) @(negedge clk);
    endtask

    task automatic load_geom();
        wr(1, enc_vert(ga[4], ga[5], ga[6], ga[7]));
        wr(2, enc_horz(ga[1], ga[2], ga[3]));
        wr(3, 32'(ga[0] - 1));
        wr(4, enc_pol());
        wr(5, 32'(mask));
    endtask

    // R8: start then check every clock; optional write at clock pk
    task automatic run_check(input int n, input int pk, input int pa, input logic [31:0] pd);
        wr(0, enc_ctrl(1, 3, ga[8]));
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == pk + 1) wr_en = 1'b0;
            check_at(k);
            if (k == pk) begin
                wr_en = 1'b1; wr_addr = 3'(pa); wr_data = pd;
            end
        end
    endtask

    task automatic t_reset();
        p_clk = 0; p_hs = 0; p_vs = 0; p_dat = 0; p_de = 0; mask = 0;
        idle_check(10, "R1");
    endtask

    task automatic t_basic();
        ga = '{2, 1, 4, 1, 1, 1, 2, 1, 0};
        load_geom();
        run_check(170, -1, 0, 32'd0);   // R3 R4 R5 R7 over two frames
    endtask

    task automatic t_divider();
        stop_gen();
        ga[8] = 2;
        run_check(260, -1, 0, 32'd0);   // R2 slower pixel
        stop_gen();
        ga[8] = 0;
    endtask

    task automatic t_polarity();
        p_clk = 1; p_hs = 1; p_vs = 1; p_dat = 1; p_de = 1;
        wr(4, enc_pol());
        repeat (2) @(negedge clk);
        idle_check(6, "R6");            // inverted rest levels while stopped
        run_check(100, -1, 0, 32'd0);   // R6 inverted running strobes
        stop_gen();
        idle_check(4, "R1");
    endtask

    task automatic t_mode();
        wr(0, enc_ctrl(1, 2, 0));       // R9 wrong panel mode
        idle_check(40, "R9");
        wr(0, enc_ctrl(1, 1, 0));
        idle_check(20, "R9");
        stop_gen();
        p_clk = 0; p_hs = 0; p_vs = 0; p_dat = 0; p_de = 0;
        wr(4, enc_pol());
        repeat (2) @(negedge clk);
    endtask

    task automatic t_mask();
        mask = 1;
        wr(5, 32'd1);
        run_check(170, -1, 0, 32'd0);   // R7 irq suppressed, pulse kept
        stop_gen();
        mask = 0;
        wr(5, 32'd0);
    endtask

    task automatic t_update();
        gb = ga;
        gb[1] = 2; gb[2] = 5; gb[3] = 2;
        k_switch = 80;                  // R8 old geometry until frame wrap
        run_check(80 + 230, 30, 2, enc_horz(2, 5, 2));
        stop_gen();
        k_switch = 1000000;
        ga = gb;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_divider();
        t_polarity();
        t_mode();
        t_mask();
        t_update();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule